// File: doc/BRIEF.md
# Keyboard Controller Serial Slave with Attention Handshake

This block sits on the peripheral side of a four-wire serial link between a host and a keyboard controller. The host drives an active-low select, a serial clock and a data line into the block. The block samples all three into its own system clock domain through multi-flop synchronizers and assembles incoming bits into bytes, one bit per rising serial clock edge. The host may send several bytes back to back while select stays low. Each completed byte is presented for one system clock, and a marker flags the first byte of each transfer. A select release that cuts a byte short discards the partial bits and raises a one-cycle framing-error pulse.

On the return path the block carries no data of its own. It tells the host that a report is waiting. The controller logic pulses a request input. The block then pulls its active-low attention output low and drives the serial data-out line high. When the host next finishes a transfer by releasing select, attention is withdrawn. A request that arrives while select is low is kept, and it raises attention only once the transfer has ended.

Byte width, synchronizer depth and bit order are parameters. Bits arrive most significant first by default.

Top module: `kbd_spi_slave`

## Requirements
- R1: While reset is held and directly after it, attn_n_o is 1, miso_o is 0, byte_vld_o is 0 and frame_err_o is 0.
- R2: With select low, the block samples the data line on each rising serial clock edge. After DATA_W such edges byte_o carries those bits, the first bit received in bit DATA_W-1 (default order).
- R3: byte_vld_o is high for exactly one system clock per completed byte. Several bytes sent within one select-low period each produce their own pulse, in order.
- R4: first_o is 1 together with byte_vld_o for the first byte after select goes low, and 0 for every later byte of the same transfer.
- R5: Serial clock edges while select is high produce no byte and leave the bit count at zero, so the next transfer starts on a byte boundary.
- R6: Releasing select after 1 to DATA_W-1 bits of a byte produces one frame_err_o pulse of one clock and no byte_vld_o. The next transfer's first byte is received intact.
- R7: A request pulse on rpt_req_i while select is high drives attn_n_o to 0 and miso_o to 1 within three system clocks.
- R8: Once select is released at the end of a transfer, an asserted attention is withdrawn: attn_n_o returns to 1 and miso_o to 0.
- R9: A request that arrives while select is low leaves attn_n_o at 1 until select is released. Attention is then raised without a further request.
- R10: miso_o is 1 exactly when attn_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sel_n_i | input | 1 | Active-low select from the host (asynchronous) |
| mosi_i | input | 1 | Serial data from the host (asynchronous) |
| miso_o | output | 1 | Serial data to the host; high while attention is asserted |
| attn_n_o | output | 1 | Active-low attention to the host |
| rpt_req_i | input | 1 | Request from the controller to alert the host (system clock domain) |
| byte_o | output | DATA_W | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| first_o | output | 1 | Marks the first byte of a transfer, valid with byte_vld_o |
| frame_err_o | output | 1 | One-cycle pulse when a partial byte is discarded |

## Verification
The bench goes after the edges of a transfer. It sends multi-byte transfers, where a design that cleared its marker late or never would flag the wrong byte as first. It toggles the serial clock with select high, which a design counting those edges would answer with a misaligned byte in the next transfer. It releases select mid-byte, which a design without a bit-count reset would answer with a shifted byte and no error pulse. For the attention path, it issues a request inside an open transfer. A design that raised attention at once would break the hold rule, and one that dropped the request would never raise attention at all. A seeded random mix of byte counts and data then checks every received byte and marker against a list the bench keeps.

// File: rtl/kbd_spi_pkg.sv
package kbd_spi_pkg;

   typedef enum logic {
      ORD_MSB_FIRST = 1'b0,
      ORD_LSB_FIRST = 1'b1
   } bit_order_e;

   // lane positions inside the synchronizer vector
   localparam int unsigned LANE_SCLK = 0;
   localparam int unsigned LANE_SEL  = 1;
   localparam int unsigned LANE_DATA = 2;
   localparam int unsigned LANES     = 3;

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
   parameter int unsigned     W       = 3,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("kbd_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("kbd_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_rx_shift.sv
module kbd_rx_shift #(
   parameter int unsigned              DATA_W = 8,
   parameter kbd_spi_pkg::bit_order_e  ORDER  = kbd_spi_pkg::ORD_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise_i,
   input  logic              sel_fall_i,
   input  logic              sel_rise_i,
   input  logic              sel_idle_i,
   input  logic              data_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              vld_o,
   output logic              first_o,
   output logic              ferr_o
);

   localparam int unsigned CNT_W = (DATA_W < 2) ? 1 : $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("kbd_rx_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shreg_nxt;
   logic              first_pend_q;
   logic              take_bit;
   logic              last_bit;

   assign take_bit = sclk_rise_i && !sel_idle_i;
   assign last_bit = (cnt_q == LAST_BIT);

   generate
      if (ORDER == kbd_spi_pkg::ORD_MSB_FIRST) begin : g_msb
         assign shreg_nxt = {shreg_q[DATA_W-2:0], data_i};
      end else begin : g_lsb
         assign shreg_nxt = {data_i, shreg_q[DATA_W-1:1]};
      end
   endgenerate

   // bit counter and shift register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (sel_idle_i) begin
         cnt_q   <= '0;
      end else if (take_bit) begin
         shreg_q <= shreg_nxt;
         cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
      end
   end

   // first-byte marker of the current transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_pend_q <= 1'b0;
      end else if (sel_fall_i) begin
         first_pend_q <= 1'b1;
      end else if (sel_rise_i || (take_bit && last_bit)) begin
         first_pend_q <= 1'b0;
      end
   end

   // byte presentation and framing error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o  <= '0;
         vld_o   <= 1'b0;
         first_o <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         vld_o   <= take_bit && last_bit;
         first_o <= take_bit && last_bit && first_pend_q;
         ferr_o  <= sel_rise_i && (cnt_q != '0);
         if (take_bit && last_bit) byte_o <= shreg_nxt;
      end
   end

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o); // R3

   AST_FIRST_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      first_o |-> vld_o); // R4

   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_idle_i && $past(sel_idle_i)) |-> (cnt_q == '0 && !vld_o)); // R5

   AST_FERR_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_o |-> ($past(sel_rise_i) && !vld_o)); // R6

endmodule

// File: rtl/kbd_attn_ctl.sv
module kbd_attn_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic sel_idle_i,
   input  logic sel_rise_i,
   output logic attn_o
);

   logic pend_q;
   logic attn_q;
   logic raise;

   assign raise = pend_q && sel_idle_i && !sel_rise_i && !attn_q;

   // a request is held until it can be shown to the host
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (req_i) pend_q <= 1'b1;
      else if (raise) pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          attn_q <= 1'b0;
      else if (sel_rise_i) attn_q <= 1'b0;
      else if (raise)      attn_q <= 1'b1;
   end

   assign attn_o = attn_q;

   AST_NO_RAISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(attn_q) |-> $past(sel_idle_i)); // R9

   AST_DROP_ON_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise_i && attn_q) |=> !attn_q); // R8

   AST_IDLE_REQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && sel_idle_i && !sel_rise_i && !attn_q) |=> attn_q); // R7

endmodule

// File: rtl/kbd_spi_slave.sv
module kbd_spi_slave #(
   parameter int unsigned              DATA_W      = 8,
   parameter int unsigned              SYNC_STAGES = 2,
   parameter kbd_spi_pkg::bit_order_e  ORDER       = kbd_spi_pkg::ORD_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sel_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              attn_n_o,
   input  logic              rpt_req_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              byte_vld_o,
   output logic              first_o,
   output logic              frame_err_o
);

   import kbd_spi_pkg::*;

   localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_SEL;

   logic [LANES-1:0] raw_in;
   logic [LANES-1:0] synced;
   logic             sclk_s, sel_s, data_s;
   logic             sclk_d, sel_d;
   logic             sclk_rise, sel_rise, sel_fall;
   logic             attn;

   assign raw_in[LANE_SCLK] = sclk_i;
   assign raw_in[LANE_SEL]  = sel_n_i;
   assign raw_in[LANE_DATA] = mosi_i;

   kbd_sync #(
      .W       (LANES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (synced)
   );

   assign sclk_s = synced[LANE_SCLK];
   assign sel_s  = synced[LANE_SEL];
   assign data_s = synced[LANE_DATA];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         sel_d  <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         sel_d  <= sel_s;
      end
   end

   assign sclk_rise = sclk_s && !sclk_d;
   assign sel_rise  = sel_s && !sel_d;
   assign sel_fall  = !sel_s && sel_d;

   kbd_rx_shift #(
      .DATA_W (DATA_W),
      .ORDER  (ORDER)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_rise_i (sclk_rise),
      .sel_fall_i  (sel_fall),
      .sel_rise_i  (sel_rise),
      .sel_idle_i  (sel_s),
      .data_i      (data_s),
      .byte_o      (byte_o),
      .vld_o       (byte_vld_o),
      .first_o     (first_o),
      .ferr_o      (frame_err_o)
   );

   kbd_attn_ctl u_attn (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (rpt_req_i),
      .sel_idle_i (sel_s),
      .sel_rise_i (sel_rise),
      .attn_o     (attn)
   );

   assign attn_n_o = !attn;
   assign miso_o   = attn;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (attn_n_o && !miso_o && !byte_vld_o && !frame_err_o)); // R1

   AST_BYTE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> $past(!sel_s)); // R2

endmodule

// File: tb/kbd_spi_slave_tb.sv
`timescale 1ns/1ps
module kbd_spi_slave_tb;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0;
   logic          sel_n = 1'b1;
   logic          mosi = 1'b0;
   logic          rpt_req = 1'b0;
   logic          miso, attn_n, bvld, first, ferr;
   logic [DW-1:0] bval;

   always #2.5 clk = ~clk;

   kbd_spi_slave #(.DATA_W(DW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (sclk),
      .sel_n_i     (sel_n),
      .mosi_i      (mosi),
      .miso_o      (miso),
      .attn_n_o    (attn_n),
      .rpt_req_i   (rpt_req),
      .byte_o      (bval),
      .byte_vld_o  (bvld),
      .first_o     (first),
      .frame_err_o (ferr)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // observed stream
   logic [DW-1:0] cap_byte  [256];
   logic          cap_first [256];
   int            cap_n   = 0;
   int            ferr_n  = 0;
   int            dbl_n   = 0;
   logic          prev_vld = 1'b0;

   // expected stream
   logic [DW-1:0] exp_byte  [256];
   logic          exp_first [256];
   int            exp_n   = 0;
   int            cmp_n   = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bvld && cap_n < 256) begin
            cap_byte[cap_n]  = bval;
            cap_first[cap_n] = first;
            cap_n++;
         end
         if (bvld && prev_vld) dbl_n++;
         if (ferr) ferr_n++;
         prev_vld = bvld;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic bit_of(input logic [DW-1:0] b, input int i);
      return b[DW-1-i];   // first bit on the wire is the top bit
   endfunction

   function automatic logic first_of(input int idx_in_xfer);
      return (idx_in_xfer == 0);
   endfunction

   task automatic clks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bits(input logic [DW-1:0] b, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         mosi = bit_of(b, i);
         sclk = 1'b0;
         clks(4);
         sclk = 1'b1;
         clks(4);
      end
      sclk = 1'b0;
      clks(4);
   endtask

   task automatic sel_on();
      sel_n = 1'b0;
      clks(6);
   endtask

   task automatic sel_off();
      sel_n = 1'b1;
      clks(8);
   endtask

   task automatic push_exp(input logic [DW-1:0] b, input logic f);
      exp_byte[exp_n]  = b;
      exp_first[exp_n] = f;
      exp_n++;
   endtask

   task automatic xfer(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                       input logic [DW-1:0] b2, input logic [DW-1:0] b3, input int nb);
      logic [DW-1:0] bs [4];
      bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
      sel_on();
      for (int k = 0; k < nb; k++) begin
         send_bits(bs[k], DW);
         push_exp(bs[k], first_of(k));
      end
      sel_off();
   endtask

   task automatic compare(input string req);
      check(cap_n == exp_n, req, cap_n, exp_n);
      for (int i = cmp_n; i < exp_n && i < cap_n; i++) begin
         check(cap_byte[i] == exp_byte[i], req, cap_byte[i], exp_byte[i]);
         check(cap_first[i] == exp_first[i], {req, " first"}, cap_first[i], exp_first[i]);
      end
      cmp_n = exp_n;
   endtask

   task automatic pulse_req();
      rpt_req = 1'b1;
      clks(1);
      rpt_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int f0;
      void'($urandom(32'h5EED_0042));

      // R1 reset state
      clks(3);
      check(attn_n === 1'b1 && miso === 1'b0 && bvld === 1'b0 && ferr === 1'b0,
            "R1 in reset", {attn_n, miso, bvld, ferr}, 4'b1000);
      rst_n = 1'b1;
      clks(4);
      check(attn_n === 1'b1 && miso === 1'b0 && bvld === 1'b0 && ferr === 1'b0,
            "R1 after reset", {attn_n, miso, bvld, ferr}, 4'b1000);

      // R2 R3 R4: three bytes in one transfer
      xfer(8'hA5, 8'h3C, 8'hFF, 8'h00, 3);
      compare("R2 R3 R4 multi-byte");
      check(dbl_n == 0, "R3 strobe width", dbl_n, 0);

      // R5: clock activity with select high
      for (int i = 0; i < 11; i++) begin
         sclk = 1'b1; clks(4);
         sclk = 1'b0; clks(4);
      end
      check(cap_n == exp_n, "R5 no byte while idle", cap_n, exp_n);
      xfer(8'h81, 8'h00, 8'h00, 8'h00, 1);
      compare("R5 alignment kept");

      // R6: partial byte then a clean transfer
      f0 = ferr_n;
      sel_on();
      send_bits(8'hF0, 5);
      sel_off();
      check(ferr_n == f0 + 1, "R6 error pulse", ferr_n, f0 + 1);
      check(cap_n == exp_n, "R6 partial dropped", cap_n, exp_n);
      xfer(8'h5A, 8'h00, 8'h00, 8'h00, 1);
      compare("R6 next transfer intact");
      check(ferr_n == f0 + 1, "R6 no extra error", ferr_n, f0 + 1);

      // R7 R10: request while idle
      pulse_req();
      clks(3);
      check(attn_n === 1'b0, "R7 attention raised", attn_n, 0);
      check(miso === ~attn_n, "R10 data-out high", miso, ~attn_n);

      // R8: host transfer clears attention
      xfer(8'h12, 8'h00, 8'h00, 8'h00, 1);
      compare("R8 byte during attention");
      check(attn_n === 1'b1, "R8 attention released", attn_n, 1);
      check(miso === ~attn_n, "R10 data-out low", miso, ~attn_n);

      // R9: request inside a transfer
      sel_on();
      send_bits(8'hC3, 4);
      pulse_req();
      clks(5);
      check(attn_n === 1'b1, "R9 held mid-byte", attn_n, 1);
      send_bits(8'hC3 << 4, 4);
      push_exp(8'hC3, 1'b1);
      check(attn_n === 1'b1, "R9 held before release", attn_n, 1);
      sel_off();
      check(attn_n === 1'b0, "R9 raised after release", attn_n, 0);
      check(miso === ~attn_n, "R10 after held request", miso, ~attn_n);
      compare("R9 byte");
      xfer(8'h77, 8'h00, 8'h00, 8'h00, 1);
      check(attn_n === 1'b1, "R8 second release", attn_n, 1);

      // random transfers
      for (int t = 0; t < 20; t++) begin
         int nb;
         nb = 1 + int'($urandom_range(3));
         xfer(DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom), nb);
      end
      compare("R2 R3 R4 random");
      check(dbl_n == 0, "R3 strobe width random", dbl_n, 0);
      check(ferr_n == f0 + 1, "R6 no spurious error", ferr_n, f0 + 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule